// File: doc/BRIEF.md
# Generalized Reverse and OR-Combine Unit

A purely combinational bit-permutation unit for an integer datapath of XLEN bits (32 or 64). It takes a data operand, a control amount and two mode selects, and in the same cycle returns a permuted result and a flag telling whether that result is all zeros. The operation is built from log2(XLEN) fixed stages. Stage k trades every aligned group of 2^k bits with its neighbouring group of the same size. A stage runs only when bit k of the control amount is set.

In reverse mode an enabled stage replaces the running value with its swapped form, so one unit can do bit, nibble, byte or halfword reversal and many other regular permutations. In OR-combine mode an enabled stage ORs the swapped form into the running value instead. This spreads any set bit across all of the groups that the selected stages join, which is useful for tests of the form "any bit in this byte". A word select limits either operation to the low 32 bits, with the upper bits cleared. An execution pipeline would place the unit between its operand read and its write-back.

Top module: `grev_gorc_unit`

## Requirements
- R1: With a control amount of zero (after the modulo of R4), the result equals the operand in both modes (in word mode, the operand's low 32 bits, zero-extended).
- R2: With orSel=0 (reverse mode), result bit i equals operand bit (i XOR a), where a is the effective control amount. Each set bit k of a swaps adjacent groups of 2^k bits, and the stages run from group size 1 upward.
- R3: With orSel=1 (OR-combine mode), result bit i is the OR of every operand bit j whose index differs from i only in bit positions that are set in a.
- R4: Only the low log2(XLEN) bits of ctrlAmt are used. Higher control bits have no effect on the result.
- R5: In reverse mode, a control amount of XLEN-1 reverses the full bit order of the operand.
- R6: With wordSel=1, only the low 32 operand bits are used, only control bits 0 to 4 take effect, and result bits 32 and up are zero.
- R7: zeroOut is 1 exactly when resultOut is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opndIn | input | XLEN | Data operand |
| ctrlAmt | input | CTRL_W | Control amount; only the low log2(XLEN) bits are used |
| orSel | input | 1 | 0 = reverse, 1 = OR-combine |
| wordSel | input | 1 | 1 = operate on the low 32 bits only |
| resultOut | output | XLEN | Permuted or combined result |
| zeroOut | output | 1 | High when resultOut is zero |

## Verification
The checks are immediate and are evaluated whenever the combinational inputs settle. They assume that every input is at a known 0 or 1, because unknown bits would break the population-count and superset relations they test. The bench always drives fully defined values: operands and control amounts come from $urandom with a fixed seed, and the control bits above log2(XLEN) are filled with random values on purpose so that the modulo rule is exercised.

// File: rtl/grev_gorc_pkg.sv
package grev_gorc_pkg;
  localparam int MAX_STAGES = 6;
  localparam int WORD_STAGES = 5;

  typedef struct packed {
    logic [MAX_STAGES-1:0] stageEn;
    logic                  orMode;
    logic                  wordMode;
  } stage_ctrl_t;
endpackage

// File: rtl/grev_gorc_ctrl.sv
module grev_gorc_ctrl
  import grev_gorc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CTRL_W = 8
) (
  input  logic [CTRL_W-1:0] ctrlAmt,
  input  logic              orSel,
  input  logic              wordSel,
  output stage_ctrl_t       strobes
);
  localparam int STAGES = $clog2(XLEN);

  always_comb begin
    strobes.stageEn = '0;
    for (int k = 0; k < STAGES; k++) begin
      strobes.stageEn[k] = ctrlAmt[k] && !(wordSel && k >= WORD_STAGES);
    end
    strobes.orMode = orSel;
    strobes.wordMode = wordSel;
  end

  always_comb begin
    // R6
    word_stage_cut_chk: assert (!(wordSel && strobes.stageEn[MAX_STAGES-1]));
  end
endmodule

// File: rtl/grev_gorc_datapath.sv
module grev_gorc_datapath
  import grev_gorc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] opndIn,
  input  stage_ctrl_t     strobes,
  output logic [XLEN-1:0] resultOut,
  output logic            zeroOut
);
  localparam int STAGES = $clog2(XLEN);

  function automatic logic [XLEN-1:0] lowGroupMask(int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = ((i >> k) & 1) == 0;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] wordMask();
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = (i < 32);
    return m;
  endfunction

  localparam logic [XLEN-1:0] WORD_MASK = wordMask();

  logic [XLEN-1:0] maskedIn;
  logic [XLEN-1:0] stg [0:STAGES];

  assign maskedIn = strobes.wordMode ? (opndIn & WORD_MASK) : opndIn;
  assign stg[0] = maskedIn;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam logic [XLEN-1:0] LO = lowGroupMask(k);
    localparam int SH = 1 << k;
    logic [XLEN-1:0] swapped;
    assign swapped = ((stg[k] & LO) << SH) | ((stg[k] & ~LO) >> SH);
    assign stg[k+1] = !strobes.stageEn[k] ? stg[k] :
                      strobes.orMode ? (stg[k] | swapped) : swapped;
  end

  assign resultOut = stg[STAGES];
  assign zeroOut = (resultOut == '0);

  always_comb begin
    // R1
    zero_ctrl_pass_chk: assert (strobes.stageEn != '0 || resultOut == maskedIn);
    // R2
    grev_popcount_chk: assert (strobes.orMode || $countones(resultOut) == $countones(maskedIn));
    // R3
    gorc_superset_chk: assert (!strobes.orMode || (resultOut & maskedIn) == maskedIn);
    // R7
    zero_flag_chk: assert (zeroOut == (maskedIn == '0));
  end
endmodule

// File: rtl/grev_gorc_unit.sv
module grev_gorc_unit
  import grev_gorc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CTRL_W = 8
) (
  input  logic [XLEN-1:0]   opndIn,
  input  logic [CTRL_W-1:0] ctrlAmt,
  input  logic              orSel,
  input  logic              wordSel,
  output logic [XLEN-1:0]   resultOut,
  output logic              zeroOut
);
  stage_ctrl_t strobes;

  grev_gorc_ctrl #(.XLEN(XLEN), .CTRL_W(CTRL_W)) u_ctrl (
    .ctrlAmt(ctrlAmt), .orSel(orSel), .wordSel(wordSel), .strobes(strobes)
  );

  grev_gorc_datapath #(.XLEN(XLEN)) u_dp (
    .opndIn(opndIn), .strobes(strobes), .resultOut(resultOut), .zeroOut(zeroOut)
  );

  if (XLEN > 32) begin : g_upper_chk
    always_comb begin
      // R6
      word_upper_zero_chk: assert (!wordSel || resultOut[XLEN-1:32] == '0);
    end
  end
endmodule

// File: tb/grev_gorc_unit_test.sv
module grev_gorc_unit_test;
  localparam int XLEN = 64;
  localparam int CTRL_W = 8;
  localparam int STAGES = $clog2(XLEN);

  logic clk = 0;
  logic rst = 1;
  logic [XLEN-1:0] opndIn;
  logic [CTRL_W-1:0] ctrlAmt;
  logic orSel, wordSel;
  logic [XLEN-1:0] resultOut;
  logic zeroOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  grev_gorc_unit #(.XLEN(XLEN), .CTRL_W(CTRL_W)) uut (
    .opndIn(opndIn), .ctrlAmt(ctrlAmt), .orSel(orSel), .wordSel(wordSel),
    .resultOut(resultOut), .zeroOut(zeroOut)
  );

  function automatic logic [XLEN-1:0] expRes(logic [XLEN-1:0] op, logic [CTRL_W-1:0] amt,
                                             logic orS, logic wrd);
    int w = wrd ? 32 : XLEN;
    int a = wrd ? int'(amt[4:0]) : int'(amt[STAGES-1:0]);
    logic [XLEN-1:0] r = '0;
    for (int i = 0; i < w; i++) begin
      if (!orS) r[i] = op[i ^ a];
      else
        for (int j = 0; j < w; j++)
          if (((i ^ j) & ~a) == 0) r[i] = r[i] | op[j];
    end
    return r;
  endfunction

  task automatic apply(input logic [XLEN-1:0] op, input logic [CTRL_W-1:0] amt,
                       input logic orS, input logic wrd, input string tag);
    logic [XLEN-1:0] e;
    @(negedge clk);
    opndIn = op; ctrlAmt = amt; orSel = orS; wordSel = wrd;
    #2;
    e = expRes(op, amt, orS, wrd);
    checks++;
    if (resultOut !== e) begin
      errors++;
      $display("FAIL %s result: actual %h expected %h (op %h amt %h or %0d word %0d)",
               tag, resultOut, e, op, amt, orS, wrd);
    end
    checks++;
    if (zeroOut !== (e == '0)) begin
      errors++;
      $display("FAIL R7 zero flag: actual %0d expected %0d", zeroOut, (e == '0));
    end
  endtask

  task automatic expectVal(input logic [XLEN-1:0] e, input string tag);
    checks++;
    if (resultOut !== e) begin
      errors++;
      $display("FAIL %s literal: actual %h expected %h", tag, resultOut, e);
    end
  endtask

  initial begin
    logic [XLEN-1:0] r1;
    opndIn = '0; ctrlAmt = '0; orSel = 0; wordSel = 0;
    void'($urandom(32'h1234));
    repeat (3) @(posedge clk);
    rst = 0;
    // idle inputs after reset: zero result and zero flag set
    apply('0, '0, 0, 0, "R7");
    expectVal('0, "R7");
    // R1 pass-through in both modes
    apply(64'hDEAD_BEEF_0123_4567, 8'h00, 0, 0, "R1");
    expectVal(64'hDEAD_BEEF_0123_4567, "R1");
    apply(64'hDEAD_BEEF_0123_4567, 8'h00, 1, 0, "R1");
    expectVal(64'hDEAD_BEEF_0123_4567, "R1");
    apply(64'hDEAD_BEEF_0123_4567, 8'h00, 0, 1, "R1");
    expectVal(64'h0000_0000_0123_4567, "R1");
    // R5 full reversal
    apply(64'h1, 8'd63, 0, 0, "R5");
    expectVal(64'h8000_0000_0000_0000, "R5");
    apply(64'h0123_4567_89AB_CDEF, 8'd63, 0, 0, "R5");
    expectVal(64'hF7B3_D591_E6A2_C480, "R5");
    // R2 byte swap within halfwords
    apply(64'h1122_3344_5566_7788, 8'd8, 0, 0, "R2");
    expectVal(64'h2211_4433_6655_8877, "R2");
    // R3 gorc byte OR-combine
    apply(64'h0000_0100_0000_0080, 8'd7, 1, 0, "R3");
    expectVal(64'h0000_FF00_0000_00FF, "R3");
    apply(64'h1, 8'd63, 1, 0, "R3");
    expectVal('1, "R3");
    // R4 upper control bits ignored
    apply(64'h0F0F_1234_ABCD_0001, 8'hC5, 0, 0, "R4");
    r1 = resultOut;
    apply(64'h0F0F_1234_ABCD_0001, 8'h05, 0, 0, "R4");
    expectVal(r1, "R4");
    // R6 word mode
    apply(64'hFFFF_FFFF_0000_0001, 8'd31, 0, 1, "R6");
    expectVal(64'h0000_0000_8000_0000, "R6");
    apply(64'hAAAA_AAAA_1234_5678, 8'h20, 0, 1, "R6");
    expectVal(64'h0000_0000_1234_5678, "R6");
    apply(64'hFFFF_FFFF_0000_0000, 8'd31, 1, 1, "R6");
    expectVal('0, "R6");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [XLEN-1:0] op = {$urandom, $urandom};
      logic [CTRL_W-1:0] amt = CTRL_W'($urandom);
      logic o = 1'($urandom);
      logic w = ($urandom % 4) == 0;
      if (n % 17 == 0) op = '0;
      apply(op, amt, o, w, w ? "R6" : (o ? "R3" : "R2"));
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule